// File: doc/BRIEF.md
# CAN Bus Wake-Up Pattern Detector

This block belongs to the low-power control logic of a CAN transceiver. While the transceiver rests in standby, it watches a one-bit bus level from the wake-up comparator, where 1 means dominant and 0 means recessive. It asks for a wake-up only when it sees a complete, debounced pattern: a dominant phase, then a recessive phase, then a second dominant phase. Each phase must last at least a filter time. The pattern must also complete inside a time window. A level held steady for any length of time never causes a wake-up. Neither does a burst of short spikes.

The bus level first passes through a two-flop synchronizer. A level filter then accepts a new level only after it has been present for `FILT_CYC` consecutive cycles. The sequence tracker opens its window on the first accepted dominant level and closes it after `WAKE_CYC` cycles. The request is shown as an active-low level meant for the receive-data pin, together with a one-cycle pulse. The level stays low until standby is left.

Top module: `canwake_detect`

## Requirements
- R1: After reset, `wake_n` is 1 and `wake_pulse` is 0.
- R2: A bus level (`bus_dom` = 1 dominant, 0 recessive) counts as a phase only if it is held for at least `FILT_CYC` consecutive cycles. A dominant–recessive–dominant pattern whose recessive gap is `FILT_CYC`-1 cycles long gives no wake-up.
- R3: A pattern of dominant for D ≥ `FILT_CYC` cycles, then recessive for R ≥ `FILT_CYC` cycles, then dominant produces a wake-up. `wake_n` goes to 0 on the (`FILT_CYC`+2)-th rising clock edge, counting as the first the earliest edge at which the second dominant level is present on `bus_dom`.
- R4: A spike shorter than `FILT_CYC` cycles inside a phase neither ends that phase nor counts as a phase, so the pattern still completes with unchanged timing.
- R5: The window is measured at the input from the start of the first dominant phase to the start of the second. With D+R ≤ `WAKE_CYC` the request is raised. With D+R = `WAKE_CYC`+1 the tracker has already returned to its start state and no request follows.
- R6: A dominant level held far longer than the window, and then released, raises no request.
- R7: `wake_pulse` is 1 for exactly one cycle per request, in the cycle where `wake_n` first reads 0.
- R8: Once raised, `wake_n` stays 0 whatever the bus does, until `enable` is 0 or `supply_low` is 1 at a rising edge. After that edge it reads 1.
- R9: While `enable` is 0 or `supply_low` is 1, no request is raised even for a valid pattern. `wake_n` reads 1 and `wake_pulse` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High while the transceiver is in standby |
| supply_low | input | 1 | Supply undervoltage flag; blocks and clears detection |
| bus_dom | input | 1 | Comparator bus level, 1 = dominant |
| wake_n | output | 1 | Latched wake request, active low |
| wake_pulse | output | 1 | One-cycle strobe when the request is raised |

## Verification
The window expiry and the completion of the second dominant phase can fall on the same edge. That edge is reached when D+R equals `WAKE_CYC` exactly, and completion must win, so the bench drives that pattern and expects a request. It then drives D+R one cycle longer and expects none. Together, the two runs pin the tie to the completing side.

// File: rtl/canwake_detect.sv
module canwake_detect #(
  parameter int FILT_CYC = 8,
  parameter int WAKE_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic supply_low,
  input  logic bus_dom,
  output logic wake_n,
  output logic wake_pulse
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int TW = $clog2(WAKE_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_DOM1, S_REC, S_WOKE} st_t;

  logic [1:0]    sync;
  logic          flt;
  logic [FW-1:0] run;
  logic [TW-1:0] tmr;
  st_t           st;

  wire active = enable & ~supply_low;
  wire lvl    = sync[1];
  wire differ = lvl != flt;
  wire settle = differ && (run == FW'(FILT_CYC - 1));
  wire rise   = settle & lvl;
  wire fall   = settle & ~lvl;
  wire expire = tmr == TW'(WAKE_CYC - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[0], bus_dom};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt <= 1'b0;
      run <= '0;
    end else if (!active || !differ) begin
      if (!active) flt <= 1'b0;
      run <= '0;
    end else if (settle) begin
      flt <= lvl;
      run <= '0;
    end else begin
      run <= run + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_IDLE;
      tmr        <= '0;
      wake_pulse <= 1'b0;
    end else if (!active) begin
      st         <= S_IDLE;
      tmr        <= '0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      case (st)
        S_IDLE:
          if (rise) begin
            st  <= S_DOM1;
            tmr <= '0;
          end
        S_DOM1, S_REC:
          if (st == S_REC && rise) begin
            st         <= S_WOKE;
            wake_pulse <= 1'b1;
          end else if (expire) begin
            st <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
            if (st == S_DOM1 && fall) st <= S_REC;
          end
        default: st <= S_WOKE;
      endcase
    end

  assign wake_n = st != S_WOKE;
endmodule

// File: rtl/canwake_detect_chk.sv
module canwake_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic supply_low,
  input logic wake_n,
  input logic wake_pulse
);
  a_r7_pulse_with_low: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !wake_n);

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  a_r7_fall_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_n) |-> wake_pulse);

  a_r8_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !supply_low && !wake_n) |=> !wake_n);

  a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || supply_low) |=> (wake_n && !wake_pulse));
endmodule

bind canwake_detect canwake_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .supply_low(supply_low),
  .wake_n(wake_n), .wake_pulse(wake_pulse)
);

// File: tb/canwake_detect_test.sv
module canwake_detect_test;
  localparam int F = 8;
  localparam int W = 200;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, supply_low = 1'b0, bus_dom = 1'b0;
  logic wake_n, wake_pulse;
  int   checks = 0, errors = 0, pulses = 0;

  canwake_detect #(.FILT_CYC(F), .WAKE_CYC(W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .supply_low(supply_low),
    .bus_dom(bus_dom), .wake_n(wake_n), .wake_pulse(wake_pulse));

  always #5 clk = ~clk;
  always @(negedge clk) if (wake_pulse) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic lv, input int n);
    bus_dom = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    bus_dom = 1'b0; supply_low = 1'b0; enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    repeat (F + 4) @(negedge clk);
    pulses = 0;
  endtask

  task automatic no_wake(input string req, input int d, input int r);
    drive(1'b1, d); drive(1'b0, r); drive(1'b1, F + 10); drive(1'b0, F + 4);
    check(req, wake_n, 1);
    check(req, pulses, 0);
  endtask

  task automatic expect_wake(input string req, input int d, input int r);
    drive(1'b1, d); drive(1'b0, r);
    bus_dom = 1'b1;
    repeat (F + 1) @(posedge clk);
    @(negedge clk);
    check({req, " before"}, wake_n, 1);
    @(negedge clk);
    check({req, " low"}, wake_n, 0);
    check("R7 pulse", wake_pulse, 1);
    @(negedge clk);
    check("R7 pulse ends", wake_pulse, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 wake_n", wake_n, 1);
    check("R1 pulse", wake_pulse, 0);
    rst_n = 1'b1;
    quiet();
  endtask

  task automatic t_glitches();
    for (int i = 0; i < 6; i++) begin drive(1'b1, F - 1); drive(1'b0, F - 1); end
    drive(1'b0, 2 * F);
    check("R2 short pulses", wake_n, 1);
    quiet();
    no_wake("R2 short gap", 20, F - 1);
    quiet();
  endtask

  task automatic t_valid();
    expect_wake("R3 min phases", F, F);
    check("R7 one pulse", pulses, 1);
    quiet();
  endtask

  task automatic t_spike();
    drive(1'b1, 12); drive(1'b0, 2); drive(1'b1, 12);
    drive(1'b0, 10); drive(1'b1, 3);
    expect_wake("R4 spikes", 0, 10);
    quiet();
  endtask

  task automatic t_window();
    expect_wake("R5 edge of window", 20, W - 20);
    quiet();
    no_wake("R5 one cycle late", 20, W - 19);
    quiet();
  endtask

  task automatic t_long();
    no_wake("R6 long dominant", 3 * W, 0);
    quiet();
  endtask

  task automatic t_latch();
    expect_wake("R8 setup", 20, 20);
    for (int i = 0; i < 5; i++) begin drive(1'b1, 15); drive(1'b0, 15); end
    check("R8 held low", wake_n, 0);
    check("R8 single pulse", pulses, 1);
    enable = 1'b0;
    @(negedge clk);
    check("R8 cleared", wake_n, 1);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 stays clear", wake_n, 1);
    quiet();
  endtask

  task automatic t_blocked();
    enable = 1'b0;
    no_wake("R9 disabled", 20, 20);
    enable = 1'b1; supply_low = 1'b1;
    no_wake("R9 undervoltage", 20, 20);
    check("R9 pulse low", wake_pulse, 0);
    quiet();
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_glitches();
    t_valid();
    t_spike();
    t_window();
    t_long();
    t_latch();
    t_blocked();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule